// File: doc/BRIEF.md
# Parcel-to-instruction length assembler

This fetch-stage block takes a stream of 16-bit parcels from an instruction buffer and turns them into whole instructions. The two lowest bits of the first parcel give the length: any value other than binary 11 marks a 16-bit compressed instruction. The value 11 marks a 32-bit instruction, and the following parcel supplies its upper half. Each issued instruction comes with its own address, the address of the instruction after it, and exception flags. An illegal flag is raised for a compressed instruction when compressed support is off. A misalignment flag is raised for a redirect target that the current configuration cannot execute.

A redirect (flush) drops any half-built instruction and loads a new fetch address. The block also extracts the compact three-bit register fields and the compressed shift amount from each issued instruction, so a later decoder can use them directly. It does not expand compressed instructions and does not decode them fully.

Top module: `lenAsm`

## Requirements
- R1: An accepted first parcel whose bits [1:0] are not 2'b11 is issued one cycle later with instValid=1, instData = {16'h0, parcel}, instLen32=0, succPc = instPc + 2.
- R2: An accepted first parcel with bits [1:0] = 2'b11 is kept. The next accepted parcel becomes bits [31:16], and the instruction is issued one cycle after that second parcel with instLen32=1 and succPc = instPc + 4.
- R3: instValid stays 0 while only the lower half of a 32-bit instruction has been taken, no matter how long the second parcel is delayed.
- R4: exIllegal is 1 with a 16-bit instruction issued while cExtEn=0. It is 0 for every 32-bit instruction and whenever cExtEn=1.
- R5: A flush with cExtEn=0 and flushPc[1:0] != 0 sets exMisaligned for exactly the next cycle and loads trapPc with flushPc. With cExtEn=1 a target with bit 1 set raises nothing.
- R6: While flush is 1, parcelReady is 0 and parcels are ignored. Any held lower half is dropped. The first instruction issued afterwards has instPc = flushPc, and instValid is 0 in the cycle after a flush.
- R7: cRegA = 8 + instData[4:2] and cRegB = 8 + instData[9:7].
- R8: cShamt = {instData[12], instData[6:2]}, except that a zero value reads as 64.
- R9: After reset instValid, exIllegal and exMisaligned are 0, and the first instruction is fetched from RESET_PC.
- R10: Without an intervening flush, each issued instruction's instPc equals the previous one's succPc.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| flush | input | 1 | Redirect: drop partial state and reload the fetch address |
| flushPc | input | PC_W | New fetch address for a redirect |
| cExtEn | input | 1 | Compressed instructions allowed |
| parcelData | input | 16 | Incoming 16-bit parcel |
| parcelValid | input | 1 | parcelData holds a parcel |
| parcelReady | output | 1 | Block takes the parcel this cycle |
| instValid | output | 1 | One-cycle strobe: a whole instruction is presented |
| instData | output | 32 | Assembled instruction, upper half zero for 16-bit |
| instLen32 | output | 1 | 1 for a 32-bit instruction, 0 for 16-bit |
| instPc | output | PC_W | Address of the presented instruction |
| succPc | output | PC_W | Address of the following instruction |
| exIllegal | output | 1 | Compressed instruction while compressed support is off |
| exMisaligned | output | 1 | Redirect target misaligned for the current mode |
| trapPc | output | PC_W | Address recorded with the last misaligned redirect |
| cRegA | output | 5 | Register number from compact field bits [4:2] |
| cRegB | output | 5 | Register number from compact field bits [9:7] |
| cShamt | output | 7 | Compressed shift amount, zero read as 64 |

## Verification
A wrong held-half flag shows at the ports within one accepted parcel. Either a compressed parcel is glued into a 32-bit word, or a lower half is issued alone with the wrong length and a +2 successor. A fetch address that is off by one step breaks the instPc-to-succPc chain at the next issue. A stale partial state after a redirect shows as an instruction whose instPc is not the flush target. Because the bench model compares every output on every clock, each of these is seen in the first cycle it becomes visible.

// File: rtl/lenAsmPkg.sv
package lenAsmPkg;

  localparam int PARCEL_W = 16;
  localparam int INST_W   = 2 * PARCEL_W;
  localparam int CREG_W   = 5;
  localparam int CFIELD_W = 3;
  localparam int SHAMT_W  = 7;
  localparam logic [CREG_W-1:0] CREG_BASE = 5'd8;

  typedef struct packed {
    logic reload;
    logic grabLow;
    logic issue16;
    logic issue32;
  } asmStrobeT;

  function automatic logic isFullLen(input logic [1:0] lowBits);
    return lowBits == 2'b11;
  endfunction

endpackage

// File: rtl/lenAsmCtrl.sv
module lenAsmCtrl
  import lenAsmPkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      flush,
  input  logic      parcelValid,
  input  logic [1:0] parcelLow,
  output logic      parcelReady,
  output asmStrobeT strobe
);

  logic haveLow;
  logic accept;
  logic fullLen;

  assign parcelReady = ~flush;
  assign accept      = parcelValid & parcelReady;
  assign fullLen     = isFullLen(parcelLow);

  always_comb begin
    strobe         = '0;
    strobe.reload  = flush;
    strobe.grabLow = accept & ~haveLow & fullLen;
    strobe.issue16 = accept & ~haveLow & ~fullLen;
    strobe.issue32 = accept & haveLow;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      haveLow <= 1'b0;
    end else if (strobe.reload) begin
      haveLow <= 1'b0;
    end else if (strobe.grabLow) begin
      haveLow <= 1'b1;
    end else if (strobe.issue32) begin
      haveLow <= 1'b0;
    end
  end

endmodule

// File: rtl/lenAsmPath.sv
module lenAsmPath
  import lenAsmPkg::*;
#(
  parameter int PC_W = 32,
  parameter logic [PC_W-1:0] RESET_PC = '0
) (
  input  logic                clk,
  input  logic                rstN,
  input  asmStrobeT           strobe,
  input  logic [PARCEL_W-1:0] parcelData,
  input  logic [PC_W-1:0]     flushPc,
  input  logic                cExtEn,
  output logic                instValid,
  output logic [INST_W-1:0]   instData,
  output logic                instLen32,
  output logic [PC_W-1:0]     instPc,
  output logic [PC_W-1:0]     succPc,
  output logic                exIllegal,
  output logic                exMisaligned,
  output logic [PC_W-1:0]     trapPc,
  output logic [CREG_W-1:0]   cRegA,
  output logic [CREG_W-1:0]   cRegB,
  output logic [SHAMT_W-1:0]  cShamt
);

  localparam logic [PC_W-1:0] STEP16 = PC_W'(PARCEL_W / 8);
  localparam logic [PC_W-1:0] STEP32 = PC_W'(INST_W / 8);
  localparam int NUM_CFIELD = 2;
  localparam int RAW_SH_W   = SHAMT_W - 1;

  logic [PC_W-1:0]     fetchPc;
  logic [PARCEL_W-1:0] lowHalf;
  logic [PC_W-1:0]     nextPc16;
  logic [PC_W-1:0]     nextPc32;
  logic                badTarget;

  assign nextPc16  = fetchPc + STEP16;
  assign nextPc32  = fetchPc + STEP32;
  assign badTarget = ~cExtEn & (|flushPc[1:0]);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      fetchPc <= RESET_PC;
      lowHalf <= '0;
    end else if (strobe.reload) begin
      fetchPc <= flushPc;
    end else begin
      if (strobe.grabLow) lowHalf <= parcelData;
      if (strobe.issue16) fetchPc <= nextPc16;
      if (strobe.issue32) fetchPc <= nextPc32;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      instValid    <= 1'b0;
      instData     <= '0;
      instLen32    <= 1'b0;
      instPc       <= RESET_PC;
      succPc       <= RESET_PC;
      exIllegal    <= 1'b0;
      exMisaligned <= 1'b0;
      trapPc       <= '0;
    end else begin
      instValid    <= strobe.issue16 | strobe.issue32;
      exIllegal    <= strobe.issue16 & ~cExtEn;
      exMisaligned <= strobe.reload & badTarget;
      if (strobe.reload && badTarget) trapPc <= flushPc;
      if (strobe.issue16) begin
        instData  <= {{PARCEL_W{1'b0}}, parcelData};
        instLen32 <= 1'b0;
        instPc    <= fetchPc;
        succPc    <= nextPc16;
      end else if (strobe.issue32) begin
        instData  <= {parcelData, lowHalf};
        instLen32 <= 1'b1;
        instPc    <= fetchPc;
        succPc    <= nextPc32;
      end
    end
  end

  logic [CREG_W-1:0] cRegVec [NUM_CFIELD];

  for (genvar f = 0; f < NUM_CFIELD; f++) begin : g_cfield
    localparam int FIELD_LSB = (f == 0) ? 2 : 7;
    assign cRegVec[f] = CREG_BASE + CREG_W'(instData[FIELD_LSB +: CFIELD_W]);
  end

  assign cRegA = cRegVec[0];
  assign cRegB = cRegVec[1];

  logic [RAW_SH_W-1:0] rawShamt;
  assign rawShamt = {instData[12], instData[6:2]};
  assign cShamt   = (rawShamt == '0) ? SHAMT_W'(64) : {1'b0, rawShamt};

endmodule

// File: rtl/lenAsm.sv
module lenAsm
  import lenAsmPkg::*;
#(
  parameter int PC_W = 32,
  parameter logic [PC_W-1:0] RESET_PC = '0
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                flush,
  input  logic [PC_W-1:0]     flushPc,
  input  logic                cExtEn,
  input  logic [PARCEL_W-1:0] parcelData,
  input  logic                parcelValid,
  output logic                parcelReady,
  output logic                instValid,
  output logic [INST_W-1:0]   instData,
  output logic                instLen32,
  output logic [PC_W-1:0]     instPc,
  output logic [PC_W-1:0]     succPc,
  output logic                exIllegal,
  output logic                exMisaligned,
  output logic [PC_W-1:0]     trapPc,
  output logic [CREG_W-1:0]   cRegA,
  output logic [CREG_W-1:0]   cRegB,
  output logic [SHAMT_W-1:0]  cShamt
);

  asmStrobeT strobe;

  lenAsmCtrl i_ctrl (
    .clk         (clk),
    .rstN        (rstN),
    .flush       (flush),
    .parcelValid (parcelValid),
    .parcelLow   (parcelData[1:0]),
    .parcelReady (parcelReady),
    .strobe      (strobe)
  );

  lenAsmPath #(.PC_W(PC_W), .RESET_PC(RESET_PC)) i_path (
    .clk          (clk),
    .rstN         (rstN),
    .strobe       (strobe),
    .parcelData   (parcelData),
    .flushPc      (flushPc),
    .cExtEn       (cExtEn),
    .instValid    (instValid),
    .instData     (instData),
    .instLen32    (instLen32),
    .instPc       (instPc),
    .succPc       (succPc),
    .exIllegal    (exIllegal),
    .exMisaligned (exMisaligned),
    .trapPc       (trapPc),
    .cRegA        (cRegA),
    .cRegB        (cRegB),
    .cShamt       (cShamt)
  );

endmodule

// File: rtl/lenAsmChk.sv
module lenAsmChk #(
  parameter int PC_W = 32
) (
  input logic            clk,
  input logic            rstN,
  input logic            flush,
  input logic            parcelReady,
  input logic            instValid,
  input logic            instLen32,
  input logic [PC_W-1:0] instPc,
  input logic [PC_W-1:0] succPc,
  input logic            exIllegal,
  input logic            exMisaligned
);

  logic [PC_W-1:0] lastSucc;
  logic            chainLive;

  always_ff @(posedge clk) begin
    if (!rstN || flush) begin
      chainLive <= 1'b0;
      lastSucc  <= '0;
    end else if (instValid) begin
      chainLive <= 1'b1;
      lastSucc  <= succPc;
    end
  end

  p_step16_r1: assert property (@(posedge clk) disable iff (!rstN)
    instValid && !instLen32 |-> succPc == instPc + PC_W'(2));

  p_step32_r2: assert property (@(posedge clk) disable iff (!rstN)
    instValid && instLen32 |-> succPc == instPc + PC_W'(4));

  p_ill_short_r4: assert property (@(posedge clk) disable iff (!rstN)
    exIllegal |-> instValid && !instLen32);

  p_mis_after_flush_r5: assert property (@(posedge clk) disable iff (!rstN)
    exMisaligned |-> $past(flush));

  p_ready_low_r6: assert property (@(posedge clk) disable iff (!rstN)
    flush |-> !parcelReady);

  p_quiet_after_flush_r6: assert property (@(posedge clk) disable iff (!rstN)
    $past(flush) |-> !instValid);

  p_chain_r10: assert property (@(posedge clk) disable iff (!rstN)
    instValid && chainLive && !$past(flush) |-> instPc == lastSucc);

endmodule

bind lenAsm lenAsmChk #(.PC_W(PC_W)) i_lenAsmChk (
  .clk          (clk),
  .rstN         (rstN),
  .flush        (flush),
  .parcelReady  (parcelReady),
  .instValid    (instValid),
  .instLen32    (instLen32),
  .instPc       (instPc),
  .succPc       (succPc),
  .exIllegal    (exIllegal),
  .exMisaligned (exMisaligned)
);

// File: tb/test_lenAsm.sv
module test_lenAsm;

  localparam int CLK_PERIOD = 10;
  localparam logic [31:0] START_PC = 32'h0000_1000;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        flush = 1'b0;
  logic [31:0] flushPc = '0;
  logic        cExtEn = 1'b1;
  logic [15:0] parcelData = '0;
  logic        parcelValid = 1'b0;
  logic        parcelReady;
  logic        instValid;
  logic [31:0] instData;
  logic        instLen32;
  logic [31:0] instPc;
  logic [31:0] succPc;
  logic        exIllegal;
  logic        exMisaligned;
  logic [31:0] trapPc;
  logic [4:0]  cRegA;
  logic [4:0]  cRegB;
  logic [6:0]  cShamt;

  always #(CLK_PERIOD / 2) clk = ~clk;

  lenAsm #(.PC_W(32), .RESET_PC(START_PC)) i_lenAsm (
    .clk(clk), .rstN(rstN), .flush(flush), .flushPc(flushPc), .cExtEn(cExtEn),
    .parcelData(parcelData), .parcelValid(parcelValid), .parcelReady(parcelReady),
    .instValid(instValid), .instData(instData), .instLen32(instLen32),
    .instPc(instPc), .succPc(succPc), .exIllegal(exIllegal),
    .exMisaligned(exMisaligned), .trapPc(trapPc), .cRegA(cRegA), .cRegB(cRegB),
    .cShamt(cShamt)
  );

  int testsRun = 0;
  int testsFailed = 0;
  bit finished = 1'b0;

  // behavioural reference state
  logic [31:0] mPc, mInstPc, mSucc, mTrap, mData;
  logic [15:0] mLow;
  bit          mHave, mValid, mLen, mIll, mMis;

  always @(posedge clk) begin
    if (!rstN) begin
      mPc = START_PC; mHave = 0; mLow = 0; mValid = 0; mData = 0; mLen = 0;
      mInstPc = START_PC; mSucc = START_PC; mIll = 0; mMis = 0; mTrap = 0;
    end else begin
      mValid = 0; mIll = 0; mMis = 0;
      if (flush) begin
        mHave = 0;
        mPc = flushPc;
        if (!cExtEn && flushPc[1:0] != 2'b00) begin
          mMis = 1; mTrap = flushPc;
        end
      end else if (parcelValid) begin
        if (mHave) begin
          mValid = 1; mLen = 1; mData = {parcelData, mLow};
          mInstPc = mPc; mSucc = mPc + 4; mPc = mPc + 4; mHave = 0;
        end else if (parcelData[1:0] == 2'b11) begin
          mHave = 1; mLow = parcelData;
        end else begin
          mValid = 1; mLen = 0; mData = {16'h0, parcelData};
          mInstPc = mPc; mSucc = mPc + 2; mPc = mPc + 2;
          mIll = !cExtEn;
        end
      end
    end
  end

  task automatic check(input string req, input string what, input logic [31:0] act,
                       input logic [31:0] exp);
    testsRun++;
    if (act !== exp) begin
      testsFailed++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic logic [6:0] refShamt(input logic [31:0] d);
    logic [5:0] raw;
    raw = {d[12], d[6:2]};
    return (raw == 0) ? 7'd64 : {1'b0, raw};
  endfunction

  task automatic compareAll();
    check("R6", "parcelReady", {31'b0, parcelReady}, {31'b0, !flush});
    check("R3", "instValid", {31'b0, instValid}, {31'b0, mValid});
    check("R4", "exIllegal", {31'b0, exIllegal}, {31'b0, mIll});
    check("R5", "exMisaligned", {31'b0, exMisaligned}, {31'b0, mMis});
    check("R5", "trapPc", trapPc, mTrap);
    if (mValid) begin
      check("R1 R2", "instData", instData, mData);
      check("R1 R2", "instLen32", {31'b0, instLen32}, {31'b0, mLen});
      check("R10", "instPc", instPc, mInstPc);
      check("R1 R2", "succPc", succPc, mSucc);
      check("R7", "cRegA", {27'b0, cRegA}, 32'd8 + {29'b0, mData[4:2]});
      check("R7", "cRegB", {27'b0, cRegB}, 32'd8 + {29'b0, mData[9:7]});
      check("R8", "cShamt", {25'b0, cShamt}, {25'b0, refShamt(mData)});
    end
  endtask

  // drive at a falling edge, then compare at the next falling edge
  task automatic step(input bit fl, input logic [31:0] fpc, input bit cx,
                      input bit pv, input logic [15:0] pd);
    flush = fl; flushPc = fpc; cExtEn = cx; parcelValid = pv; parcelData = pd;
    @(negedge clk);
    compareAll();
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!finished) begin
      testsRun++; testsFailed++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
      $finish;
    end
  end

  initial begin : stimulus
    logic [15:0] lfsr;
    lfsr = 16'hACE1;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    // R9: reset state
    check("R9", "instValid after reset", {31'b0, instValid}, 32'd0);
    check("R9", "exIllegal after reset", {31'b0, exIllegal}, 32'd0);
    check("R9", "exMisaligned after reset", {31'b0, exMisaligned}, 32'd0);
    step(0, 0, 1, 1, 16'h4501);
    check("R9", "first instPc", instPc, START_PC);

    // mixed random stream
    for (int c = 0; c < 3000; c++) begin
      bit fl, cx, pv;
      logic [15:0] pd;
      logic [31:0] tgt;
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      fl  = (lfsr[9:5] == 5'd0);
      cx  = (c < 1000) ? 1'b1 : ((c < 2000) ? 1'b0 : lfsr[11]);
      pv  = lfsr[0] | lfsr[3];
      pd  = {lfsr[7:0], lfsr[15:8]};
      if (lfsr[2]) pd[1:0] = 2'b11;
      tgt = {16'h0, lfsr[15:2], lfsr[4:3]};
      step(fl, tgt, cx, pv, pd);
    end

    // directed: R8 zero shift amount, R7 field mapping of zero
    step(1, 32'h100, 1, 0, 0);
    step(0, 0, 1, 1, 16'h0001);
    check("R8", "zero shamt reads 64", {25'b0, cShamt}, 32'd64);
    check("R7", "cRegA field 0", {27'b0, cRegA}, 32'd8);
    check("R1", "instPc after flush", instPc, 32'h100);
    step(0, 0, 1, 1, 16'h139C);
    check("R7", "cRegA field 7", {27'b0, cRegA}, 32'd15);
    check("R7", "cRegB field 7", {27'b0, cRegB}, 32'd15);
    check("R8", "shamt 32+7", {25'b0, cShamt}, 32'd39);

    // directed: R2 and R3, delayed upper half
    step(0, 0, 1, 1, 16'h0033);
    for (int k = 0; k < 3; k++) begin
      step(0, 0, 1, 0, 16'hFFFF);
      check("R3", "no half issue", {31'b0, instValid}, 32'd0);
    end
    step(0, 0, 1, 1, 16'h0040);
    check("R2", "32-bit data", instData, 32'h0040_0033);
    check("R2", "32-bit succPc", succPc, 32'h104 + 32'd4);

    // directed: R6 flush drops a held half
    step(0, 0, 1, 1, 16'h0013);
    step(1, 32'h400, 1, 1, 16'h0001);
    check("R6", "no issue after flush", {31'b0, instValid}, 32'd0);
    step(0, 0, 1, 1, 16'h0005);
    check("R6", "post-flush instPc", instPc, 32'h400);
    check("R6", "post-flush length", {31'b0, instLen32}, 32'd0);

    // directed: R4 illegal compressed, R5 misaligned targets
    step(0, 0, 0, 1, 16'h0001);
    check("R4", "illegal with cExtEn=0", {31'b0, exIllegal}, 32'd1);
    step(1, 32'h202, 0, 0, 0);
    check("R5", "misaligned flag", {31'b0, exMisaligned}, 32'd1);
    check("R5", "trapPc", trapPc, 32'h202);
    step(0, 0, 0, 0, 0);
    check("R5", "flag one cycle", {31'b0, exMisaligned}, 32'd0);
    step(1, 32'h302, 1, 0, 0);
    check("R5", "no flag with cExtEn=1", {31'b0, exMisaligned}, 32'd0);

    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

endmodule